// File: doc/BRIEF.md
# Dataflow/Sequential Mode Switch Sequencer

This block moves a processing element between token-driven dataflow operation and sequential-block operation. Going into sequential mode it first copies the shared match-metadata words, one 16-bit word per cycle, into a reserved area of the otherwise idle frame memory. It then writes the matched operand pair into metadata words 0 and 1, which from then on serve as sequential registers. After that it hands the metadata address source to the instruction-register fields, and last of all it puts instruction fetch into counter mode.

Going back, it first emits the final result token. It then reads the spilled words back from frame memory, one per cycle, and writes each into the metadata store one cycle after its read. It then returns metadata addressing to the frame/activation source and finally re-opens token intake.

Token intake is held closed for the whole of each transition, so the frame memory port is never contended. The activation lookup table is not part of the shared store and keeps serving allocate/free traffic throughout. A `busy` flag covers each transition and a one-cycle `done` pulse marks its end.

Top module: `mode_switch_seq`

## Requirements
- R1: After reset the block is in dataflow mode. In that state `busy`, `done`, `seqMode`, `addrSelIr`, `fetchCounter`, `memWrEn`, `memRdEn`, `metaWrEn` and `tokOutValid` are all 0, and `intakeEn` is 1.
- R2: When an entry is accepted, memory writes occupy the next WORDS cycles (4 by default), one per cycle. In cycle k (k = 1..WORDS) the block drives `metaRdAddr` = k-1, `memAddr` = SPILL_BASE + k-1 (default base 0xF0) and `memWrData` = the metadata word returned for that address.
- R3: In the two cycles after the spill, the block writes metadata word 0 with the operand `opA` captured at acceptance, then word 1 with `opB`. Sequential register r is metadata word r, and bank b holds bits 4b+3..4b.
- R4: On entry, `addrSelIr` rises one cycle before `fetchCounter` and `seqMode` rise. On exit, `addrSelIr` falls one cycle before `fetchCounter` and `seqMode` fall.
- R5: In the first cycle after an exit is accepted, `tokOutValid` is 1 for exactly one cycle, with `tokOutData` equal to the `finalResult` captured at acceptance.
- R6: The restore reads SPILL_BASE+i in ascending order, one per cycle. It writes metadata word i with the read data one cycle later, so that read i+1 and write i share a cycle. After a full round trip every metadata word is bit-identical to its value when the entry was accepted, even if it was overwritten in between.
- R7: Each transition keeps `busy` high for WORDS+4 cycles (8 by default), and never for more than 10. `done` is a one-cycle pulse in the first cycle after `busy` falls. `seqMode` changes only at that point.
- R8: `intakeEn` is 1 only while in dataflow mode with `busy` low. `memWrEn`, `memRdEn` and `metaWrEn` are 0 whenever `busy` is 0.
- R9: The following requests start nothing: `enterReq` in sequential mode or while busy, and `exitReq` in dataflow mode or while busy. If both requests are raised at once, only the one that matches the current mode is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enterReq | input | 1 | Request to enter sequential mode |
| exitReq | input | 1 | Request to return to dataflow mode |
| opA | input | DATA_W | First operand of the triggering pair |
| opB | input | DATA_W | Second operand of the triggering pair |
| finalResult | input | DATA_W | Result carried by the final token |
| metaRdAddr | output | log2(WORDS) | Metadata word read index |
| metaRdData | input | DATA_W | Metadata word read data (combinational) |
| metaWrEn | output | 1 | Metadata word write strobe |
| metaWrAddr | output | log2(WORDS) | Metadata word write index |
| metaWrData | output | DATA_W | Metadata word write data |
| memWrEn | output | 1 | Frame memory write strobe |
| memRdEn | output | 1 | Frame memory read strobe (data valid next cycle) |
| memAddr | output | MEM_AW | Frame memory address |
| memWrData | output | DATA_W | Frame memory write data |
| memRdData | input | DATA_W | Frame memory read data |
| tokOutValid | output | 1 | Final token emit strobe |
| tokOutData | output | DATA_W | Final token payload |
| addrSelIr | output | 1 | Metadata address source is instruction-register fields |
| fetchCounter | output | 1 | Instruction fetch uses the incrementing counter |
| seqMode | output | 1 | Sequential mode active |
| intakeEn | output | 1 | Token intake from the input FIFO allowed |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle pulse when a transition completes |

## Verification
During a restore, the frame memory read of word i+1 and the metadata write of word i fall in the same cycle. Reading the wrong word or writing with the wrong delay would corrupt the store silently. The bench provokes this with a memory model of one-cycle read latency and checks every restore write's address and data cycle by cycle. After the sequential phase has deliberately scribbled over all metadata words, it compares the whole store bit for bit against the pattern saved at entry. A second overlap is a request arriving in the same cycle as an ongoing transition, or both requests arriving together. The bench holds the requests high across whole transitions and judges that only the mode-matching one starts a sequence, and that its flags never deviate.

// File: rtl/mode_switch_pkg.sv
package mode_switch_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAVE,
    ST_LOAD,
    ST_MUXON,
    ST_MODEON,
    ST_EMIT,
    ST_REST,
    ST_MUXOFF,
    ST_MODEOFF
  } stateT;

  // Per-cycle strobes from the control to the datapath
  typedef struct packed {
    logic capEnter;
    logic capExit;
    logic spillWr;
    logic loadWr;
    logic loadSel;
    logic restRd;
    logic restWr;
    logic emit;
    logic muxOn;
    logic muxOff;
    logic modeOn;
    logic modeOff;
  } strobeT;

endpackage

// File: rtl/mode_switch_ctrl.sv
module mode_switch_ctrl
  import mode_switch_pkg::*;
#(
  parameter int WORDS      = 4,
  parameter int MAX_CYCLES = 10,
  localparam int IDX_W = $clog2(WORDS),
  localparam int CNT_W = $clog2(WORDS + 1),
  localparam int RUN_W = $clog2(MAX_CYCLES + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enterReq,
  input  logic             exitReq,
  input  logic             seqMode,
  output strobeT           stb,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] wIdx,
  output logic             busy
);

  localparam logic [CNT_W-1:0] LAST_SAVE = CNT_W'(WORDS - 1);
  localparam logic [CNT_W-1:0] REST_END  = CNT_W'(WORDS);
  localparam logic [CNT_W-1:0] LAST_LOAD = CNT_W'(1);

  stateT            state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic [IDX_W-1:0] prevIdx;
  logic [RUN_W-1:0] busyRun;
  logic             takeEnter, takeExit;

  assign takeEnter = (state == ST_IDLE) && enterReq && !seqMode;
  assign takeExit  = (state == ST_IDLE) && exitReq && seqMode;
  assign busy      = (state != ST_IDLE);
  assign idx       = cnt[IDX_W-1:0];
  assign wIdx      = prevIdx;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    unique case (state)
      ST_IDLE: begin
        nextCnt = '0;
        if (takeEnter)     nextState = ST_SAVE;
        else if (takeExit) nextState = ST_EMIT;
      end
      ST_SAVE: begin
        if (cnt == LAST_SAVE) begin
          nextState = ST_LOAD;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_LOAD: begin
        if (cnt == LAST_LOAD) begin
          nextState = ST_MUXON;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_MUXON:  nextState = ST_MODEON;
      ST_MODEON: nextState = ST_IDLE;
      ST_EMIT: begin
        nextState = ST_REST;
        nextCnt   = '0;
      end
      ST_REST: begin
        if (cnt == REST_END) begin
          nextState = ST_MUXOFF;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_MUXOFF:  nextState = ST_MODEOFF;
      ST_MODEOFF: nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    stb          = '0;
    stb.capEnter = takeEnter;
    stb.capExit  = takeExit;
    stb.spillWr  = (state == ST_SAVE);
    stb.loadWr   = (state == ST_LOAD);
    stb.loadSel  = cnt[0];
    stb.restRd   = (state == ST_REST) && (cnt != REST_END);
    stb.restWr   = (state == ST_REST) && (cnt != '0);
    stb.emit     = (state == ST_EMIT);
    stb.muxOn    = (state == ST_MUXON);
    stb.muxOff   = (state == ST_MUXOFF);
    stb.modeOn   = (state == ST_MODEON);
    stb.modeOff  = (state == ST_MODEOFF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      prevIdx <= '0;
      busyRun <= '0;
    end else begin
      state   <= nextState;
      cnt     <= nextCnt;
      prevIdx <= idx;
      if (!busy)             busyRun <= '0;
      else if (busyRun != '1) busyRun <= busyRun + 1'b1;
    end
  end

  // R7: a transition never holds busy beyond the cycle budget
  assert_transition_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(MAX_CYCLES));

  // R9: idle in sequential mode without an exit request stays idle
  assert_enter_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && seqMode && !exitReq) |=> !busy);

  // R9: idle in dataflow mode without an entry request stays idle
  assert_exit_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !seqMode && !enterReq) |=> !busy);

endmodule

// File: rtl/mode_switch_dp.sv
module mode_switch_dp
  import mode_switch_pkg::*;
#(
  parameter int                DATA_W     = 16,
  parameter int                WORDS      = 4,
  parameter int                MEM_AW     = 8,
  parameter logic [MEM_AW-1:0] SPILL_BASE = 8'hF0,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [IDX_W-1:0]  wIdx,
  input  logic              busy,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] finalResult,
  output logic [IDX_W-1:0]  metaRdAddr,
  input  logic [DATA_W-1:0] metaRdData,
  output logic              metaWrEn,
  output logic [IDX_W-1:0]  metaWrAddr,
  output logic [DATA_W-1:0] metaWrData,
  output logic              memWrEn,
  output logic              memRdEn,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              tokOutValid,
  output logic [DATA_W-1:0] tokOutData,
  output logic              addrSelIr,
  output logic              fetchCounter,
  output logic              seqMode,
  output logic              intakeEn,
  output logic              done
);

  logic [DATA_W-1:0] opAQ, opBQ, resQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAQ         <= '0;
      opBQ         <= '0;
      resQ         <= '0;
      addrSelIr    <= 1'b0;
      fetchCounter <= 1'b0;
      seqMode      <= 1'b0;
      done         <= 1'b0;
    end else begin
      if (stb.capEnter) begin
        opAQ <= opA;
        opBQ <= opB;
      end
      if (stb.capExit) resQ <= finalResult;
      if (stb.muxOn)       addrSelIr <= 1'b1;
      else if (stb.muxOff) addrSelIr <= 1'b0;
      if (stb.modeOn) begin
        fetchCounter <= 1'b1;
        seqMode      <= 1'b1;
      end else if (stb.modeOff) begin
        fetchCounter <= 1'b0;
        seqMode      <= 1'b0;
      end
      done <= stb.modeOn | stb.modeOff;
    end
  end

  // Spill side: metadata read feeds the memory write in the same cycle
  assign metaRdAddr = stb.spillWr ? idx : '0;
  assign memWrEn    = stb.spillWr;
  assign memWrData  = stb.spillWr ? metaRdData : '0;
  assign memRdEn    = stb.restRd;
  assign memAddr    = (stb.spillWr | stb.restRd) ? SPILL_BASE + MEM_AW'(idx) : '0;

  // Metadata writes: operand load or delayed restore write
  assign metaWrEn   = stb.loadWr | stb.restWr;
  assign metaWrAddr = stb.loadWr ? IDX_W'(stb.loadSel) : (stb.restWr ? wIdx : '0);
  always_comb begin
    if (stb.loadWr)      metaWrData = stb.loadSel ? opBQ : opAQ;
    else if (stb.restWr) metaWrData = memRdData;
    else                 metaWrData = '0;
  end

  assign tokOutValid = stb.emit;
  assign tokOutData  = stb.emit ? resQ : '0;
  assign intakeEn    = !seqMode && !busy;

  // R8: no memory or metadata traffic outside a transition
  assert_ports_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (metaWrEn || memWrEn || memRdEn) |-> busy);

  // R7: the mode flag only moves together with the completion pulse
  assert_mode_at_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(seqMode) |-> done);

  // R7: completion pulse follows the end of busy
  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R4: address source switches before the mode on entry
  assert_mux_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqMode) |-> $past(addrSelIr));

  // R4: address source switches back before the mode on exit
  assert_mux_back_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(seqMode) |-> !$past(addrSelIr));

  // R5: a token is emitted only while in sequential mode
  assert_emit_in_seq_R5: assert property (@(posedge clk) disable iff (!rstN)
    tokOutValid |-> (seqMode && busy));

endmodule

// File: rtl/mode_switch_seq.sv
module mode_switch_seq
  import mode_switch_pkg::*;
#(
  parameter int                DATA_W     = 16,
  parameter int                WORDS      = 4,
  parameter int                MEM_AW     = 8,
  parameter logic [MEM_AW-1:0] SPILL_BASE = 8'hF0,
  parameter int                MAX_CYCLES = 10,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enterReq,
  input  logic              exitReq,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] finalResult,
  output logic [IDX_W-1:0]  metaRdAddr,
  input  logic [DATA_W-1:0] metaRdData,
  output logic              metaWrEn,
  output logic [IDX_W-1:0]  metaWrAddr,
  output logic [DATA_W-1:0] metaWrData,
  output logic              memWrEn,
  output logic              memRdEn,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              tokOutValid,
  output logic [DATA_W-1:0] tokOutData,
  output logic              addrSelIr,
  output logic              fetchCounter,
  output logic              seqMode,
  output logic              intakeEn,
  output logic              busy,
  output logic              done
);

  strobeT           stb;
  logic [IDX_W-1:0] idx, wIdx;

  mode_switch_ctrl #(
    .WORDS(WORDS), .MAX_CYCLES(MAX_CYCLES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .exitReq(exitReq),
    .seqMode(seqMode), .stb(stb), .idx(idx), .wIdx(wIdx), .busy(busy)
  );

  mode_switch_dp #(
    .DATA_W(DATA_W), .WORDS(WORDS), .MEM_AW(MEM_AW), .SPILL_BASE(SPILL_BASE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(idx), .wIdx(wIdx), .busy(busy),
    .opA(opA), .opB(opB), .finalResult(finalResult),
    .metaRdAddr(metaRdAddr), .metaRdData(metaRdData),
    .metaWrEn(metaWrEn), .metaWrAddr(metaWrAddr), .metaWrData(metaWrData),
    .memWrEn(memWrEn), .memRdEn(memRdEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData),
    .tokOutValid(tokOutValid), .tokOutData(tokOutData),
    .addrSelIr(addrSelIr), .fetchCounter(fetchCounter), .seqMode(seqMode),
    .intakeEn(intakeEn), .done(done)
  );

endmodule

// File: tb/test_mode_switch_seq.sv
module test_mode_switch_seq;

  localparam int DW = 16;
  localparam int NW = 4;
  localparam logic [7:0] BASE = 8'hF0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enterReq = 1'b0, exitReq = 1'b0;
  logic [DW-1:0] opA = '0, opB = '0, finalResult = '0;
  logic [1:0] metaRdAddr, metaWrAddr;
  logic [DW-1:0] metaRdData, metaWrData, memWrData, tokOutData;
  logic [DW-1:0] memRdData = '0;
  logic metaWrEn, memWrEn, memRdEn, tokOutValid;
  logic addrSelIr, fetchCounter, seqMode, intakeEn, busy, done;
  logic [7:0] memAddr;

  logic [DW-1:0] metaArr [NW];
  logic [DW-1:0] memArr [256];
  logic [DW-1:0] pat [NW];
  logic scWr = 1'b0;
  logic [1:0] scAddr = '0;
  logic [DW-1:0] scData = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mode_switch_seq i_mode_switch_seq (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .exitReq(exitReq),
    .opA(opA), .opB(opB), .finalResult(finalResult),
    .metaRdAddr(metaRdAddr), .metaRdData(metaRdData),
    .metaWrEn(metaWrEn), .metaWrAddr(metaWrAddr), .metaWrData(metaWrData),
    .memWrEn(memWrEn), .memRdEn(memRdEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData),
    .tokOutValid(tokOutValid), .tokOutData(tokOutData),
    .addrSelIr(addrSelIr), .fetchCounter(fetchCounter), .seqMode(seqMode),
    .intakeEn(intakeEn), .busy(busy), .done(done)
  );

  // Metadata store model: combinational read, write at the edge
  assign metaRdData = metaArr[metaRdAddr];
  always @(posedge clk) begin
    if (metaWrEn)  metaArr[metaWrAddr] <= metaWrData;
    else if (scWr) metaArr[scAddr] <= scData;
  end

  // Frame memory model: one-cycle read latency
  always @(posedge clk) begin
    if (memWrEn) memArr[memAddr] <= memWrData;
    if (memRdEn) memRdData <= memArr[memAddr];
  end

  // {busy,done,seqMode,addrSelIr,fetchCounter,intakeEn,memWrEn,memRdEn,metaWrEn,tokOutValid}
  function automatic logic [9:0] obs();
    return {busy, done, seqMode, addrSelIr, fetchCounter, intakeEn,
            memWrEn, memRdEn, metaWrEn, tokOutValid};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic setMeta(input int r);
    for (int i = 0; i < NW; i++) begin
      pat[i] = 16'((r + 1) * 40503 + i * 9973) ^ 16'(r << (i * 3));
      if (r == 7) pat[i] = 16'hFFFF;
      @(negedge clk);
      scWr = 1'b1; scAddr = 2'(i); scData = pat[i];
    end
    @(negedge clk);
    scWr = 1'b0;
  endtask

  task automatic scribble();
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      scWr = 1'b1; scAddr = 2'(i); scData = ~pat[i] ^ 16'h00A5;
    end
    @(negedge clk);
    scWr = 1'b0;
  endtask

  task automatic doEnter(input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input bit holdEnter, input bit bothAtOnce);
    @(negedge clk);
    enterReq = 1'b1; exitReq = bothAtOnce; opA = a; opB = b;
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (!holdEnter) enterReq = 1'b0;
      exitReq = 1'b0;
      opA = ~a; opB = ~b;
      if (c <= 4) begin
        chk("R2 spill flags", 32'(obs()), 32'b1000001000);
        chk("R2 spill addr", 32'(memAddr), 32'(BASE + 8'(c - 1)));
        chk("R2 spill data", 32'(memWrData), 32'(pat[c-1]));
      end else if (c <= 6) begin
        chk("R3 load flags", 32'(obs()), 32'b1000000010);
        chk("R3 load addr", 32'(metaWrAddr), 32'(c - 5));
        chk("R3 load data", 32'(metaWrData), 32'((c == 5) ? a : b));
      end else if (c == 7) begin
        chk("R4 pre-mux flags", 32'(obs()), 32'b1000000000);
      end else if (c == 8) begin
        chk("R4 mux before mode", 32'(obs()), 32'b1001000000);
      end else if (c == 9) begin
        chk("R7 entry done", 32'(obs()), 32'b0111100000);
      end else begin
        chk("R7 done single", 32'(obs()), 32'b0011100000);
      end
    end
    enterReq = 1'b0;
    for (int i = 0; i < NW; i++)
      chk("R2 spilled word", 32'(memArr[BASE + 8'(i)]), 32'(pat[i]));
    chk("R3 register 0", 32'(metaArr[0]), 32'(a));
    chk("R3 register 1", 32'(metaArr[1]), 32'(b));
  endtask

  task automatic doExit(input logic [DW-1:0] res, input bit holdExit);
    @(negedge clk);
    exitReq = 1'b1; finalResult = res;
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (!holdExit) exitReq = 1'b0;
      finalResult = ~res;
      if (c == 1) begin
        chk("R5 emit flags", 32'(obs()), 32'b1011100001);
        chk("R5 token data", 32'(tokOutData), 32'(res));
      end else if (c <= 6) begin
        chk("R6 restore flags", 32'(obs()),
            {22'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, (c <= 5), (c >= 3), 1'b0});
        if (c <= 5) chk("R6 restore read addr", 32'(memAddr), 32'(BASE + 8'(c - 2)));
        if (c >= 3) begin
          chk("R6 restore write addr", 32'(metaWrAddr), 32'(c - 3));
          chk("R6 restore write data", 32'(metaWrData), 32'(pat[c-3]));
        end
      end else if (c == 7) begin
        chk("R4 mux still set", 32'(obs()), 32'b1011100000);
      end else if (c == 8) begin
        chk("R4 mux back before mode", 32'(obs()), 32'b1010100000);
      end else if (c == 9) begin
        chk("R7 exit done", 32'(obs()), 32'b0100010000);
        exitReq = 1'b0;
      end else begin
        chk("R8 intake open", 32'(obs()), 32'b0000010000);
      end
    end
    exitReq = 1'b0;
    for (int i = 0; i < NW; i++)
      chk("R6 round trip word", 32'(metaArr[i]), 32'(pat[i]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", 32'(obs()), 32'b0000010000);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", 32'(obs()), 32'b0000010000);
    chk("R1 memAddr idle", 32'(memAddr), 32'h0);

    for (int r = 0; r < 8; r++) begin
      setMeta(r);
      // R9: exit request in dataflow mode is ignored
      @(negedge clk); exitReq = 1'b1;
      @(negedge clk); exitReq = 1'b0;
      chk("R9 exit ignored", 32'(obs()), 32'b0000010000);
      @(negedge clk);
      chk("R9 exit ignored later", 32'(obs()), 32'b0000010000);

      doEnter(16'(r * 4099 + 17), 16'(r * 771 + 3), (r % 2) == 1, r == 2);

      // R9: entry request in sequential mode is ignored
      @(negedge clk); enterReq = 1'b1;
      @(negedge clk); enterReq = 1'b0;
      chk("R9 enter ignored", 32'(obs()), 32'b0011100000);
      @(negedge clk);
      chk("R8 seq idle quiet", 32'(obs()), 32'b0011100000);

      scribble();
      doExit(16'(r * 12345 + 99), r == 3);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule